// File: doc/BRIEF.md
# Fractional-Step Sawtooth Ramp Generator

This block drives the digital code of one converter channel with a sawtooth ramp. It keeps a 16-bit accumulator in unsigned 12.4 fixed point. A reload strobe sets the accumulator to a programmed 12-bit start level with a zero fraction. An advance strobe adds the programmed 12.4 increment to the accumulator, or subtracts it, according to a direction input. The ramp code on the output is the integer part of the accumulator, so increments below one LSB build up over several advances.

Each of the two strobes comes from one of two sources, picked by its own select input. One source is a per-cycle external trigger line. The other is a software request bit. Software raises the request with a one-cycle set pulse. The bit is latched only while the select for that strobe picks the software source. It is acted on in the next cycle and then clears by itself. When both strobes fire in the same cycle, the reload wins.

Top module: `saw_ramp_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ramp_out` is 0 and both request bits `sw_load_pend` and `sw_adv_pend` are 0.
- R2: A reload strobe sets the accumulator to {`start_lvl`, 4'b0000}. `ramp_out` shows `start_lvl` after the clock edge that samples the strobe, and any earlier fraction is discarded.
- R3: With `dir_up` = 1, an advance strobe adds `step_val` to the accumulator. `step_val` bits [15:4] are the integer part and bits [3:0] are sixteenths. `ramp_out` is accumulator bits [15:4].
- R4: With `dir_up` = 0, an advance strobe subtracts `step_val` from the accumulator.
- R5: Accumulator arithmetic wraps modulo 2^16 in both directions. For example, 0xFFF plus 1.0 gives 0x000, and 0x000 minus 1.0 gives 0xFFF.
- R6: When a reload strobe and an advance strobe fire in the same cycle, only the reload takes effect.
- R7: When a select is 0 (external source), the external line fires the strobe in every cycle it is high. A software set pulse for that strobe leaves its request bit at 0 and does not change `ramp_out`.
- R8: When a select is 1 (software source), the external line for that strobe has no effect. A set pulse raises the request bit after the next edge, and the strobe takes effect on the edge after that.
- R9: A software request bit stays high for exactly one cycle. It clears on the same edge that acts on it.
- R10: Sub-LSB increments accumulate. Sixteen advances of 0x0001 raise `ramp_out` by exactly 1, and two advances of 0x0008 raise it by 1 only after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_lvl | input | 12 | Level loaded by a reload strobe |
| step_val | input | 16 | Unsigned 12.4 increment per advance |
| dir_up | input | 1 | 1 = advance adds, 0 = advance subtracts |
| load_src_sw | input | 1 | Reload source select: 0 external, 1 software |
| adv_src_sw | input | 1 | Advance source select: 0 external, 1 software |
| ext_load | input | 1 | External reload trigger, active per cycle |
| ext_adv | input | 1 | External advance trigger, active per cycle |
| sw_load_set | input | 1 | Software reload request set pulse |
| sw_adv_set | input | 1 | Software advance request set pulse |
| sw_load_pend | output | 1 | Software reload request bit |
| sw_adv_pend | output | 1 | Software advance request bit |
| ramp_out | output | 12 | Integer part of the accumulator |

## Verification
The bench checks that the fraction is kept across advances and dropped on reload. A design that shows a rounded value or keeps the old fraction after a reload moves one code off after a half-step advance. It checks wrap-around at both ends of the range, where a design that saturates would stay at 0xFFF or 0x000. It checks a reload and an advance in the same cycle, where a design that gives the advance priority shows the start level plus the step. It also checks the software request bits. A bit that latches while the external source is selected, or that stays set for more than one cycle, makes the ramp move without a matching trigger.

// File: rtl/saw_pkg.sv
package saw_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SW  = 1'b1
  } trig_src_e;

  localparam int unsigned STROBE_LOAD = 0;
  localparam int unsigned STROBE_ADV  = 1;
  localparam int unsigned N_STROBES   = 2;
endpackage

// File: rtl/saw_trig_sel.sv
module saw_trig_sel
  import saw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src_sel,
  input  logic ext_trig,
  input  logic sw_set,
  output logic sw_pend,
  output logic fire
);
  trig_src_e src;
  logic      pend_q;

  assign src = trig_src_e'(src_sel);

  // request bit latches only under software selection and lives one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= sw_set && (src == SRC_SW);
    end
  end

  always_comb begin
    if (src == SRC_SW) fire = pend_q;
    else               fire = ext_trig;
  end

  assign sw_pend = pend_q;
endmodule

// File: rtl/saw_accum.sv
module saw_accum #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic             dir_up,
  input  logic [INT_W-1:0] start_lvl,
  input  logic [ACC_W-1:0] step_val,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] load_word;
  logic [ACC_W-1:0] next_adv;

  generate
    if (FRAC_W > 0) begin : g_frac
      assign load_word = {start_lvl, {FRAC_W{1'b0}}};
    end else begin : g_nofrac
      assign load_word = start_lvl;
    end
  endgenerate

  // modulo-2^ACC_W arithmetic: carries and borrows out of the top are dropped
  always_comb begin
    if (dir_up) next_adv = acc_q + step_val;
    else        next_adv = acc_q - step_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= load_word;
    end else if (adv) begin
      acc_q <= next_adv;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/saw_ramp_gen.sv
module saw_ramp_gen
  import saw_pkg::*;
#(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] start_lvl,
  input  logic [ACC_W-1:0] step_val,
  input  logic             dir_up,
  input  logic             load_src_sw,
  input  logic             adv_src_sw,
  input  logic             ext_load,
  input  logic             ext_adv,
  input  logic             sw_load_set,
  input  logic             sw_adv_set,
  output logic             sw_load_pend,
  output logic             sw_adv_pend,
  output logic [INT_W-1:0] ramp_out
);
  logic [N_STROBES-1:0] sel_v, ext_v, set_v, pend_v, fire_v;
  logic [ACC_W-1:0]     acc;

  assign sel_v[STROBE_LOAD] = load_src_sw;
  assign sel_v[STROBE_ADV]  = adv_src_sw;
  assign ext_v[STROBE_LOAD] = ext_load;
  assign ext_v[STROBE_ADV]  = ext_adv;
  assign set_v[STROBE_LOAD] = sw_load_set;
  assign set_v[STROBE_ADV]  = sw_adv_set;

  generate
    for (genvar s = 0; s < N_STROBES; s++) begin : g_strobe
      saw_trig_sel i_sel (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (sel_v[s]),
        .ext_trig (ext_v[s]),
        .sw_set   (set_v[s]),
        .sw_pend  (pend_v[s]),
        .fire     (fire_v[s])
      );
    end
  endgenerate

  saw_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_acc (
    .clk       (clk),
    .rst       (rst),
    .load      (fire_v[STROBE_LOAD]),
    .adv       (fire_v[STROBE_ADV]),
    .dir_up    (dir_up),
    .start_lvl (start_lvl),
    .step_val  (step_val),
    .acc       (acc)
  );

  assign sw_load_pend = pend_v[STROBE_LOAD];
  assign sw_adv_pend  = pend_v[STROBE_ADV];
  assign ramp_out     = acc[ACC_W-1:FRAC_W];
endmodule

// File: rtl/saw_ramp_chk.sv
module saw_ramp_chk #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned ACC_W = INT_W + FRAC_W
) (
  input logic             clk,
  input logic             rst,
  input logic [INT_W-1:0] start_lvl,
  input logic [ACC_W-1:0] step_val,
  input logic             dir_up,
  input logic             load_src_sw,
  input logic             adv_src_sw,
  input logic             ext_load,
  input logic             ext_adv,
  input logic             sw_load_set,
  input logic             sw_adv_set,
  input logic             sw_load_pend,
  input logic             sw_adv_pend,
  input logic [INT_W-1:0] ramp_out,
  input logic [ACC_W-1:0] acc
);
  logic rst_seen_q;
  logic ld_trig, ad_trig;

  assign ld_trig = load_src_sw ? sw_load_pend : ext_load;
  assign ad_trig = adv_src_sw  ? sw_adv_pend  : ext_adv;

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: state is cleared by reset
  always @(posedge clk) begin
    if (rst_seen_q) begin
      a_r1_reset_clear: assert (ramp_out == '0 && !sw_load_pend && !sw_adv_pend);
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ld_trig |=> acc == {$past(start_lvl), {FRAC_W{1'b0}}});

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (ad_trig && !ld_trig && dir_up) |=> acc == ACC_W'($past(acc) + $past(step_val)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (ad_trig && !ld_trig && !dir_up) |=> acc == ACC_W'($past(acc) - $past(step_val)));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    (ad_trig && ld_trig) |=> ramp_out == $past(start_lvl));

  a_r7_no_latch_ext: assert property (@(posedge clk) disable iff (rst)
    (!load_src_sw && !adv_src_sw) |=> (!sw_load_pend && !sw_adv_pend));

  a_r8_ext_ignored: assert property (@(posedge clk) disable iff (rst)
    (load_src_sw && adv_src_sw && !sw_load_pend && !sw_adv_pend) |=> $stable(acc));

  a_r9_load_autoclear: assert property (@(posedge clk) disable iff (rst)
    (sw_load_pend && !sw_load_set) |=> !sw_load_pend);

  a_r9_adv_autoclear: assert property (@(posedge clk) disable iff (rst)
    (sw_adv_pend && !sw_adv_set) |=> !sw_adv_pend);
endmodule

bind saw_ramp_gen saw_ramp_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_saw_ramp_chk (
  .clk          (clk),
  .rst          (rst),
  .start_lvl    (start_lvl),
  .step_val     (step_val),
  .dir_up       (dir_up),
  .load_src_sw  (load_src_sw),
  .adv_src_sw   (adv_src_sw),
  .ext_load     (ext_load),
  .ext_adv      (ext_adv),
  .sw_load_set  (sw_load_set),
  .sw_adv_set   (sw_adv_set),
  .sw_load_pend (sw_load_pend),
  .sw_adv_pend  (sw_adv_pend),
  .ramp_out     (ramp_out),
  .acc          (acc)
);

// File: tb/test_saw_ramp_gen.sv
module test_saw_ramp_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] start_lvl;
  logic [15:0] step_val;
  logic        dir_up;
  logic        load_src_sw, adv_src_sw;
  logic        ext_load, ext_adv;
  logic        sw_load_set, sw_adv_set;
  logic        sw_load_pend, sw_adv_pend;
  logic [11:0] ramp_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  saw_ramp_gen i_saw_ramp_gen (
    .clk(clk), .rst(rst), .start_lvl(start_lvl), .step_val(step_val),
    .dir_up(dir_up), .load_src_sw(load_src_sw), .adv_src_sw(adv_src_sw),
    .ext_load(ext_load), .ext_adv(ext_adv), .sw_load_set(sw_load_set),
    .sw_adv_set(sw_adv_set), .sw_load_pend(sw_load_pend),
    .sw_adv_pend(sw_adv_pend), .ramp_out(ramp_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-cycle external pulse; returns on the negedge after the sampling edge
  task automatic ext_pulse(input bit ld, input bit ad);
    @(negedge clk); ext_load = ld; ext_adv = ad;
    @(negedge clk); ext_load = 1'b0; ext_adv = 1'b0;
  endtask

  task automatic load_lvl(input logic [11:0] lvl);
    start_lvl = lvl;
    ext_pulse(1'b1, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ramp", 16'(ramp_out), 16'h0);
    chk("R1 pend", {14'h0, sw_load_pend, sw_adv_pend}, 16'h0);
  endtask

  task automatic t_load_and_fraction;
    load_lvl(12'h100);
    chk("R2 load", 16'(ramp_out), 16'h100);
    step_val = 16'h0008; dir_up = 1'b1;
    ext_pulse(1'b0, 1'b1);
    chk("R10 half step", 16'(ramp_out), 16'h100);
    ext_pulse(1'b0, 1'b1);
    chk("R10 two halves", 16'(ramp_out), 16'h101);
    step_val = 16'h0001;
    for (int i = 0; i < 16; i++) ext_pulse(1'b0, 1'b1);
    chk("R10 sixteenths", 16'(ramp_out), 16'h102);
    ext_pulse(1'b0, 1'b1);
    ext_pulse(1'b0, 1'b1);
    ext_pulse(1'b0, 1'b1);
    load_lvl(12'h200);
    step_val = 16'h000D;
    ext_pulse(1'b0, 1'b1);
    chk("R2 fraction cleared", 16'(ramp_out), 16'h200);
  endtask

  task automatic t_up_down;
    load_lvl(12'h050);
    step_val = 16'h0128; dir_up = 1'b1;
    ext_pulse(1'b0, 1'b1);
    chk("R3 up", 16'(ramp_out), 16'h062);
    ext_pulse(1'b0, 1'b1);
    chk("R3 up frac carry", 16'(ramp_out), 16'h075);
    dir_up = 1'b0;
    ext_pulse(1'b0, 1'b1);
    chk("R4 down", 16'(ramp_out), 16'h062);
    step_val = 16'h0030;
    ext_pulse(1'b0, 1'b1);
    chk("R4 down again", 16'(ramp_out), 16'h05F);
  endtask

  task automatic t_wrap;
    load_lvl(12'hFFF);
    step_val = 16'h0010; dir_up = 1'b1;
    ext_pulse(1'b0, 1'b1);
    chk("R5 wrap up", 16'(ramp_out), 16'h000);
    dir_up = 1'b0;
    ext_pulse(1'b0, 1'b1);
    chk("R5 wrap down", 16'(ramp_out), 16'hFFF);
  endtask

  task automatic t_priority;
    load_lvl(12'h300);
    start_lvl = 12'h123; step_val = 16'h0100; dir_up = 1'b1;
    ext_pulse(1'b1, 1'b1);
    chk("R6 load wins", 16'(ramp_out), 16'h123);
  endtask

  task automatic t_ext_mode;
    load_lvl(12'h040);
    load_src_sw = 1'b0; adv_src_sw = 1'b0;
    start_lvl = 12'h777; step_val = 16'h0100;
    @(negedge clk); sw_load_set = 1'b1; sw_adv_set = 1'b1;
    @(negedge clk); sw_load_set = 1'b0; sw_adv_set = 1'b0;
    chk("R7 no latch", {14'h0, sw_load_pend, sw_adv_pend}, 16'h0);
    @(negedge clk);
    chk("R7 sw ignored", 16'(ramp_out), 16'h040);
  endtask

  task automatic t_sw_mode;
    load_lvl(12'h040);
    load_src_sw = 1'b1; adv_src_sw = 1'b1;
    start_lvl = 12'h555; step_val = 16'h0020; dir_up = 1'b1;
    ext_pulse(1'b1, 1'b1);
    @(negedge clk);
    chk("R8 ext ignored", 16'(ramp_out), 16'h040);
    @(negedge clk); sw_adv_set = 1'b1;
    @(negedge clk); sw_adv_set = 1'b0;
    chk("R9 pend set", {15'h0, sw_adv_pend}, 16'h1);
    chk("R8 not yet", 16'(ramp_out), 16'h040);
    @(negedge clk);
    chk("R8 sw advance", 16'(ramp_out), 16'h042);
    chk("R9 pend cleared", {15'h0, sw_adv_pend}, 16'h0);
    @(negedge clk);
    chk("R9 single action", 16'(ramp_out), 16'h042);
    @(negedge clk); sw_load_set = 1'b1;
    @(negedge clk); sw_load_set = 1'b0;
    chk("R9 load pend", {15'h0, sw_load_pend}, 16'h1);
    @(negedge clk);
    chk("R8 sw load", 16'(ramp_out), 16'h555);
    chk("R9 load clear", {15'h0, sw_load_pend}, 16'h0);
    load_src_sw = 1'b0; adv_src_sw = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start_lvl = '0; step_val = '0; dir_up = 1'b1;
    load_src_sw = 1'b0; adv_src_sw = 1'b0; ext_load = 1'b0; ext_adv = 1'b0;
    sw_load_set = 1'b0; sw_adv_set = 1'b0;
    t_reset();
    t_load_and_fraction();
    t_up_down();
    t_wrap();
    t_priority();
    t_ext_mode();
    t_sw_mode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule